// File: doc/BRIEF.md
# Seconds Timekeeper with Alarm

This block keeps a running count of seconds. A programmable prescaler divides the block clock down to one tick per second. Each tick advances a 32-bit seconds counter. A 32-bit alarm value is compared with the counter each time either one changes. Two sticky event flags record the alarm match and the per-second tick. Each flag drives its own interrupt line, gated by its own enable bit.

Software reaches four word registers over a simple synchronous register bus. Writes are single-cycle and reads are combinational. The prescaler register holds the divide count and a trim value. The trim value removes a few clock cycles from one prescaler period every 1024 seconds, which corrects a slow reference. If the prescaler register is all zero, the block uses a default divide count. With a 32.768 kHz clock, that default still gives a 1 Hz tick.

Register offsets on `busAddr`: 0 is the seconds counter, 1 is the alarm, 2 is the status/enable register, and 3 is the divide/trim register.

Top module: `rtc_alarm_unit`

## Requirements
- R1: After reset, all four registers read zero and both interrupt lines are low.
- R2: A write to offset 0 replaces the seconds counter, and the new value reads back from the next cycle onward. The alarm at offset 1 behaves the same way.
- R3: With divide count D (bits 15:0 of offset 3), the counter advances by one every D+1 clock cycles. A write to offset 3 restarts the prescaler, and the first increment comes D+1 cycles after the write edge.
- R4: While offset 3 holds all zeros, the prescaler uses a divide count of 32767, so one increment comes every 32768 cycles.
- R5: The trim value T sits in bits 25:16 of offset 3. After every 1024th tick counted from the last write to offset 3, the next prescaler period is max(D-T,0)+1 cycles. T=0 leaves the period unchanged.
- R6: Status bit 1 (tick pending) is set on every tick, whatever the state of its enable bit.
- R7: Status bit 0 (alarm pending) is set one cycle after an update of the counter or the alarm (a write or a tick) leaves the two equal. If the pending bit is cleared without a new update, it stays clear.
- R8: Writing a one to status bit 0 or bit 1 clears that flag, and writing a zero leaves it unchanged. If a flag is set and cleared in the same cycle, the set wins.
- R9: Status bits 2 (alarm enable) and 3 (tick enable) take the written value and read back. Bits 31:4 read zero.
- R10: `irqAlarm` is high exactly while bits 0 and 2 are both set, and `irqTick` is high exactly while bits 1 and 3 are both set.
- R11: A counter write wins over a tick on the same edge. A counter write does not move the prescaler phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also the prescaler input |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Register offset |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for `busAddr` |
| irqAlarm | output | 1 | Alarm interrupt |
| irqTick | output | 1 | Per-second tick interrupt |

## Verification
Two pairs of events can land on the same clock edge. In the first, a software counter write meets a prescaler tick. The bench restarts the prescaler with a short divide count, counts cycles so that its counter write hits the tick edge exactly, and then checks that the written value survives and the following increment arrives on the original phase. In the second, a write-one-to-clear meets an alarm set. The bench issues the clear back-to-back with the counter write that creates the match, and checks that the pending bit is still set.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;

  localparam int ST_ALARM_PEND = 0;
  localparam int ST_TICK_PEND  = 1;
  localparam int ST_ALARM_EN   = 2;
  localparam int ST_TICK_EN    = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_SECS    = 2'd0,
    REG_ALARM   = 2'd1,
    REG_STATUS  = 2'd2,
    REG_DIVTRIM = 2'd3
  } regSel_e;

  typedef struct packed {
    logic              secsWr;
    logic              alarmWr;
    logic              divWr;
    logic [DATA_W-1:0] wrData;
  } dpStrobe_t;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV_W       = 16,
  parameter int TRIM_W      = 10,
  parameter int TRIM_PERIOD = 1024,
  parameter int DEFAULT_DIV = 32767
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadEn,
  input  logic [DIV_W-1:0]  loadDiv,
  input  logic [DIV_W-1:0]  curDiv,
  input  logic [TRIM_W-1:0] curTrim,
  output logic              tick
);
  localparam int TCNT_W = (TRIM_PERIOD > 1) ? $clog2(TRIM_PERIOD) : 1;

  logic [DIV_W-1:0]  cnt;
  logic [TCNT_W-1:0] tcnt;
  logic [DIV_W-1:0]  trimExt;
  logic [DIV_W-1:0]  trimmedDiv;
  logic              wrapNow;

  assign tick       = (cnt == '0);
  assign trimExt    = DIV_W'(curTrim);
  assign trimmedDiv = (trimExt >= curDiv) ? '0 : (curDiv - trimExt);
  assign wrapNow    = (tcnt == TCNT_W'(TRIM_PERIOD - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt  <= DIV_W'(DEFAULT_DIV);
      tcnt <= '0;
    end else if (loadEn) begin
      cnt  <= loadDiv;
      tcnt <= '0;
    end else if (tick) begin
      cnt  <= wrapNow ? trimmedDiv : curDiv;
      tcnt <= wrapNow ? '0 : tcnt + 1'b1;
    end else begin
      cnt  <= cnt - 1'b1;
    end
  end

  // R3: a restart loads the requested count
  p_load_phase_r3: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> cnt == $past(loadDiv));

  // R5: a reload never exceeds the programmed count
  p_reload_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !loadEn) |=> cnt <= $past(curDiv));
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int TRIM_W      = 10,
  parameter int TRIM_PERIOD = 1024,
  parameter int DEFAULT_DIV = 32767,
  localparam int DT_W       = DIV_W + TRIM_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  output logic [DATA_W-1:0] secs,
  output logic [DATA_W-1:0] alarm,
  output logic [DT_W-1:0]   divTrim,
  output logic              tick,
  output logic              alarmHit
);
  logic [DIV_W-1:0] effDiv;
  logic [DIV_W-1:0] loadDiv;
  logic [DT_W-1:0]  wrDivTrim;
  logic             cmpPending;

  assign wrDivTrim = strobe.wrData[DT_W-1:0];
  assign effDiv    = (divTrim == '0)   ? DIV_W'(DEFAULT_DIV) : divTrim[DIV_W-1:0];
  assign loadDiv   = (wrDivTrim == '0) ? DIV_W'(DEFAULT_DIV) : wrDivTrim[DIV_W-1:0];

  rtc_prescaler #(
    .DIV_W(DIV_W), .TRIM_W(TRIM_W),
    .TRIM_PERIOD(TRIM_PERIOD), .DEFAULT_DIV(DEFAULT_DIV)
  ) u_prescaler (
    .clk(clk), .rstN(rstN),
    .loadEn(strobe.divWr), .loadDiv(loadDiv),
    .curDiv(effDiv), .curTrim(divTrim[DT_W-1:DIV_W]),
    .tick(tick)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secs       <= '0;
      alarm      <= '0;
      divTrim    <= '0;
      cmpPending <= 1'b0;
    end else begin
      if (strobe.secsWr)     secs <= strobe.wrData;
      else if (tick)         secs <= secs + 32'd1;
      if (strobe.alarmWr)    alarm <= strobe.wrData;
      if (strobe.divWr)      divTrim <= wrDivTrim;
      cmpPending <= strobe.secsWr | strobe.alarmWr | tick;
    end
  end

  assign alarmHit = cmpPending && (secs == alarm);

  // R11: software write beats a coincident tick
  p_write_wins_r11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.secsWr |=> secs == $past(strobe.wrData));

  // R3: each tick advances the count by one
  p_tick_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !strobe.secsWr) |=> secs == $past(secs) + 32'd1);

  // R2: without a write or a tick the count holds
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !strobe.secsWr) |=> $stable(secs));
endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int DT_W = 26
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [DATA_W-1:0] secs,
  input  logic [DATA_W-1:0] alarm,
  input  logic [DT_W-1:0]   divTrim,
  input  logic              tick,
  input  logic              alarmHit,
  output dpStrobe_t         strobe,
  output logic [DATA_W-1:0] busRdData,
  output logic              irqAlarm,
  output logic              irqTick
);
  logic alarmFlag, tickFlag, alarmEn, tickEn;
  logic stWr;

  assign stWr = busWrEn && (busAddr == REG_STATUS);

  always_comb begin
    strobe         = '0;
    strobe.wrData  = busWrData;
    strobe.secsWr  = busWrEn && (busAddr == REG_SECS);
    strobe.alarmWr = busWrEn && (busAddr == REG_ALARM);
    strobe.divWr   = busWrEn && (busAddr == REG_DIVTRIM);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      alarmFlag <= 1'b0;
      tickFlag  <= 1'b0;
      alarmEn   <= 1'b0;
      tickEn    <= 1'b0;
    end else begin
      if (alarmHit)                               alarmFlag <= 1'b1;
      else if (stWr && busWrData[ST_ALARM_PEND])  alarmFlag <= 1'b0;
      if (tick)                                   tickFlag <= 1'b1;
      else if (stWr && busWrData[ST_TICK_PEND])   tickFlag <= 1'b0;
      if (stWr) begin
        alarmEn <= busWrData[ST_ALARM_EN];
        tickEn  <= busWrData[ST_TICK_EN];
      end
    end
  end

  always_comb begin
    busRdData = '0;
    case (busAddr)
      REG_SECS:    busRdData = secs;
      REG_ALARM:   busRdData = alarm;
      REG_STATUS:  busRdData = {28'd0, tickEn, alarmEn, tickFlag, alarmFlag};
      default:     busRdData = DATA_W'(divTrim);
    endcase
  end

  assign irqAlarm = alarmFlag & alarmEn;
  assign irqTick  = tickFlag & tickEn;

  // R6: a tick always leaves its flag set
  p_tick_sets_r6: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> tickFlag);

  // R7, R8: a match leaves the alarm flag set even against a clear
  p_hit_sets_r7: assert property (@(posedge clk) disable iff (!rstN)
    alarmHit |=> alarmFlag);

  // R8: writing zero to a pending bit keeps it
  p_zero_keeps_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stWr && !busWrData[ST_ALARM_PEND] && !alarmHit) |=> alarmFlag == $past(alarmFlag));
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
  import rtc_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int TRIM_W      = 10,
  parameter int TRIM_PERIOD = 1024,
  parameter int DEFAULT_DIV = 32767
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  busAddr,
  input  logic        busWrEn,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData,
  output logic        irqAlarm,
  output logic        irqTick
);
  localparam int DT_W = DIV_W + TRIM_W;

  dpStrobe_t         strobe;
  logic [DATA_W-1:0] secs, alarm;
  logic [DT_W-1:0]   divTrim;
  logic              tick, alarmHit;

  rtc_datapath #(
    .DIV_W(DIV_W), .TRIM_W(TRIM_W),
    .TRIM_PERIOD(TRIM_PERIOD), .DEFAULT_DIV(DEFAULT_DIV)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .secs(secs), .alarm(alarm), .divTrim(divTrim),
    .tick(tick), .alarmHit(alarmHit)
  );

  rtc_ctrl #(.DT_W(DT_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .secs(secs), .alarm(alarm), .divTrim(divTrim),
    .tick(tick), .alarmHit(alarmHit),
    .strobe(strobe), .busRdData(busRdData),
    .irqAlarm(irqAlarm), .irqTick(irqTick)
  );
endmodule

// File: tb/sim_rtc_alarm_unit.sv
`timescale 1ns/1ps
module sim_rtc_alarm_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = 32'd0;
  logic [31:0] busRdData;
  logic        irqAlarm, irqTick;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  rtc_alarm_unit u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData),
    .irqAlarm(irqAlarm), .irqTick(irqTick)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [31:0] v);
    busAddr = a; #1; v = busRdData;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, s;
    int divList[5] = '{1, 2, 3, 5, 8};
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      readReg(a[1:0], v); check("R1", v, 32'd0);
    end
    check("R1 irq", {30'd0, irqAlarm, irqTick}, 32'd0);

    // R2 counter and alarm writes
    writeReg(2'd0, 32'h1234_5678); readReg(2'd0, v); check("R2 secs", v, 32'h1234_5678);
    writeReg(2'd1, 32'h0000_ABCD); readReg(2'd1, v); check("R2 alarm", v, 32'h0000_ABCD);

    // R3 period sweep; R6 flag sets with enable off; R10 line stays low
    foreach (divList[i]) begin
      writeReg(2'd3, divList[i]);
      readReg(2'd0, s);
      for (int p = 1; p <= 3; p++) begin
        waitCyc(divList[i]);  readReg(2'd0, v); check("R3 before", v, s + p - 1);
        waitCyc(1);           readReg(2'd0, v); check("R3 after", v, s + p);
      end
    end
    readReg(2'd2, v); check("R6 tick flag", v & 32'h2, 32'h2);
    check("R10 tick line gated", {31'd0, irqTick}, 32'd0);

    // R7 alarm via counter write, exact cycle
    writeReg(2'd3, 1000);
    writeReg(2'd2, 32'h3);
    writeReg(2'd1, 77);
    writeReg(2'd0, 77);
    readReg(2'd2, v); check("R7 not yet", v & 32'h1, 32'h0);
    waitCyc(1); readReg(2'd2, v); check("R7 set", v & 32'h1, 32'h1);
    writeReg(2'd2, 32'h1);
    waitCyc(4); readReg(2'd2, v); check("R7 one-shot", v & 32'h1, 32'h0);

    // R7 alarm via alarm write
    writeReg(2'd1, 77); waitCyc(1);
    readReg(2'd2, v); check("R7 alarm write", v & 32'h1, 32'h1);

    // R8 set and clear on same edge: set wins
    writeReg(2'd2, 32'h1);
    writeReg(2'd1, 900);
    writeReg(2'd0, 900);
    writeReg(2'd2, 32'h1);
    readReg(2'd2, v); check("R8 set wins", v & 32'h1, 32'h1);
    writeReg(2'd2, 32'h1);
    readReg(2'd2, v); check("R8 clear", v & 32'h1, 32'h0);

    // R8 R9 R10 sweep of every status write value
    writeReg(2'd1, 42);
    for (int w = 0; w < 16; w++) begin
      logic [3:0] wv;
      logic [3:0] ex;
      wv = w[3:0];
      writeReg(2'd3, 1); waitCyc(2);
      writeReg(2'd3, 1000);
      writeReg(2'd0, 42); waitCyc(1);
      writeReg(2'd2, {28'd0, wv});
      ex = {wv[3:2], ~wv[1:0]};
      readReg(2'd2, v); check("R8 R9 status", v, {28'd0, ex});
      check("R10 alarm line", {31'd0, irqAlarm}, {31'd0, ex[0] & ex[2]});
      check("R10 tick line",  {31'd0, irqTick},  {31'd0, ex[1] & ex[3]});
    end

    // R11 counter write on the tick edge
    writeReg(2'd3, 3);
    waitCyc(3);
    writeReg(2'd0, 500);
    readReg(2'd0, v); check("R11 write wins", v, 500);
    waitCyc(3); readReg(2'd0, v); check("R11 phase hold", v, 500);
    waitCyc(1); readReg(2'd0, v); check("R11 phase kept", v, 501);

    // R5 trim shortens one period
    writeReg(2'd3, (2 << 16) | 5);
    readReg(2'd3, v); check("R5 readback", v, (2 << 16) | 5);
    readReg(2'd0, s);
    waitCyc(1024 * 6); readReg(2'd0, v); check("R5 1024 ticks", v, s + 1024);
    waitCyc(3); readReg(2'd0, v); check("R5 short before", v, s + 1024);
    waitCyc(1); readReg(2'd0, v); check("R5 short after", v, s + 1025);
    waitCyc(5); readReg(2'd0, v); check("R5 normal before", v, s + 1025);
    waitCyc(1); readReg(2'd0, v); check("R5 normal after", v, s + 1026);

    // R5 trim larger than divide count saturates to one cycle
    writeReg(2'd3, (9 << 16) | 3);
    readReg(2'd0, s);
    waitCyc(1024 * 4); readReg(2'd0, v); check("R5 sat base", v, s + 1024);
    waitCyc(1); readReg(2'd0, v); check("R5 sat one", v, s + 1025);

    // R5 zero trim leaves period unchanged
    writeReg(2'd3, 3);
    readReg(2'd0, s);
    waitCyc(1025 * 4 - 1); readReg(2'd0, v); check("R5 no trim", v, s + 1024);
    waitCyc(1); readReg(2'd0, v); check("R5 no trim", v, s + 1025);

    // R4 zero register uses the default count
    writeReg(2'd3, 0);
    readReg(2'd3, v); check("R4 readback", v, 0);
    readReg(2'd0, s);
    waitCyc(32767); readReg(2'd0, v); check("R4 before", v, s);
    waitCyc(1);     readReg(2'd0, v); check("R4 after", v, s + 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule